// File: doc/BRIEF.md
# Cross-Neighbourhood Cluster Filter

This block performs two-dimensional zero suppression on a stream of unsigned samples. The samples form a frame of `rows` x `cols` values, with time bins along a row and channels down the columns, and they arrive one per accepted cycle in row-major order. For every position in the frame the block looks at a plus-shaped neighbourhood of five values: the sample itself and the samples directly above, below, left and right of it. A position survives only when the neighbourhood contains enough activity. At least one of the five values must be strictly above a high threshold, which marks a real cluster. At least two of the five must be strictly above a low threshold, which collects the weaker charge around that cluster. Every other position is dropped, so isolated noise never reaches the output.

Two line buffers, each one row long, hold the previous rows so that the rows above and below are available when a position is decided. The row length, the row count and both thresholds are programmable, and they are captured with the first sample of each frame. When a frame has been fully received the block drains its pipeline with zero-valued virtual samples. During that drain it holds `in_ready` low. Each surviving position leaves the block as a record made of its row index, its column index and its value. The final position of every frame carries an end-of-frame flag, and that flag is set whether or not the position survives.

Top module: `xzs_cluster_filter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` and `out_eof` are 0, and `in_ready` is 1 as long as `cfg_rows` and `cfg_cols` are non-zero.
- R2: A position is emitted (`out_valid`=1) if and only if, among its five cross values (centre, up, down, left, right), at least one is above `cfg_hi_thr` and at least two are above `cfg_lo_thr`.
- R3: Every comparison is a strict unsigned greater-than. A value equal to a threshold does not count toward that threshold.
- R4: A neighbour that lies outside the frame counts as 0. Values from the end of the previous row, from the start of the next row, or from an earlier frame never take its place.
- R5: An emitted record carries the centre's row index on `out_row`, its column index on `out_col` and its unchanged sample value on `out_data`. Indices start at 0 in the top-left corner.
- R6: Records leave in row-major order. `out_eof` is 1 for exactly one cycle per frame, in the cycle that reports position (`rows`-1, `cols`-1). In that cycle `out_valid` shows whether the last position was kept.
- R7: After the last sample of a frame has been accepted, `in_ready` stays 0 for exactly `cols`+1 cycles. Data offered during those cycles is not taken.
- R8: `cfg_rows`, `cfg_cols`, `cfg_hi_thr` and `cfg_lo_thr` are sampled together with the first sample of a frame. Changes to them later in the same frame have no effect on that frame.
- R9: A sample is consumed only in a cycle with `in_valid` and `in_ready` both 1. Idle cycles inside a frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cols | input | $clog2(MAX_COLS+1) | Samples per row, 1..MAX_COLS |
| cfg_rows | input | $clog2(MAX_ROWS+1) | Rows per frame, 1..MAX_ROWS |
| cfg_hi_thr | input | DATA_W | Cluster-seed threshold |
| cfg_lo_thr | input | DATA_W | Surrounding-charge threshold |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | DATA_W | Unsigned input sample |
| out_valid | output | 1 | Kept record present |
| out_row | output | $clog2(MAX_ROWS) | Row index of the record |
| out_col | output | $clog2(MAX_COLS) | Column index of the record |
| out_data | output | DATA_W | Sample value of the record |
| out_eof | output | 1 | Record is the last position of the frame |

## Verification
The hardest case to reach from the ports is one where stale data sits right next to a position and could be mistaken for a neighbour. That stale data can be the last sample of the previous row, the first sample of the next row, or the bottom row of the previous frame still held in a line buffer. The stimulus places strong values at the last column of one row and the first column of the next, which are adjacent in the stream but not in the frame. It then runs a frame whose bottom row is saturated, followed at once by a frame with a lone moderate value in its top row. Any leak would turn a dropped position into a kept one. While each drain is running the driver keeps offering a full-scale value, so a sample taken during a drain would corrupt both the next frame's records and the measured drain length.

// File: rtl/xzs_pkg.sv
package xzs_pkg;

   // Position of each value inside the five-point cross.
   typedef enum logic [2:0] {
      TAP_C = 3'd0,
      TAP_N = 3'd1,
      TAP_S = 3'd2,
      TAP_W = 3'd3,
      TAP_E = 3'd4
   } tap_e;

   localparam int unsigned NTAPS  = 5;
   localparam int unsigned NLINES = 2;

   function automatic int unsigned pop_taps(input logic [NTAPS-1:0] bits);
      int unsigned n;
      n = 0;
      for (int i = 0; i < int'(NTAPS); i++) begin
         n = n + int'(bits[i]);
      end
      return n;
   endfunction

endpackage

// File: rtl/xzs_linebuf.sv
// One row of delay: read-before-write circular store addressed by a shared
// pointer that wraps at the programmed row length.
module xzs_linebuf #(
   parameter int unsigned DW    = 12,
   parameter int unsigned DEPTH = 64,
   parameter int unsigned AW    = 6
) (
   input  logic          clk,
   input  logic          adv,
   input  logic [AW-1:0] ptr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("xzs_linebuf: DEPTH must be at least 1");
   end
   if ((1 << AW) < DEPTH) begin : g_bad_aw
      $error("xzs_linebuf: AW too narrow for DEPTH");
   end

   logic [DW-1:0] mem [DEPTH];

   assign rd_data = mem[ptr];

   always_ff @(posedge clk) begin
      if (adv) begin
         mem[ptr] <= wr_data;
      end
   end

endmodule

// File: rtl/xzs_cross_eval.sv
// Combinational cross decision: counts enabled taps above each threshold.
module xzs_cross_eval
   import xzs_pkg::*;
#(
   parameter int unsigned DW     = 12,
   parameter int unsigned HI_MIN = 1,
   parameter int unsigned LO_MIN = 2
) (
   input  logic [NTAPS-1:0][DW-1:0] taps,
   input  logic [NTAPS-1:0]         tap_en,
   input  logic [DW-1:0]            hi_thr,
   input  logic [DW-1:0]            lo_thr,
   output logic                     keep
);

   if (HI_MIN < 1 || HI_MIN > NTAPS) begin : g_bad_hi
      $error("xzs_cross_eval: HI_MIN out of range");
   end
   if (LO_MIN < 1 || LO_MIN > NTAPS) begin : g_bad_lo
      $error("xzs_cross_eval: LO_MIN out of range");
   end

   logic [NTAPS-1:0] over_hi;
   logic [NTAPS-1:0] over_lo;

   // A disabled tap stands for an out-of-frame zero; zero never exceeds an
   // unsigned threshold, so disabling the compare is equivalent.
   for (genvar g = 0; g < NTAPS; g++) begin : g_cmp
      assign over_hi[g] = tap_en[g] && (taps[g] > hi_thr);
      assign over_lo[g] = tap_en[g] && (taps[g] > lo_thr);
   end

   assign keep = (pop_taps(over_hi) >= HI_MIN) && (pop_taps(over_lo) >= LO_MIN);

endmodule

// File: rtl/xzs_scan_ctrl.sv
// Frame sequencing: input acceptance, drain, line-buffer pointer and the
// coordinates of the position whose cross is complete.
module xzs_scan_ctrl #(
   parameter int unsigned CW = 7,
   parameter int unsigned RW = 7,
   parameter int unsigned XW = 6,
   parameter int unsigned YW = 6,
   parameter int unsigned QW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_cols,
   input  logic [RW-1:0] cfg_rows,
   input  logic          in_valid,
   output logic          in_ready,
   output logic          adv,
   output logic          frame_start,
   output logic [XW-1:0] ptr,
   output logic          cen_valid,
   output logic          cen_last,
   output logic [YW-1:0] cen_row,
   output logic [XW-1:0] cen_col,
   output logic [CW-1:0] lat_cols,
   output logic [RW-1:0] lat_rows
);

   logic [QW-1:0] step;       // index of the stream slot consumed next
   logic [XW-1:0] ptr_q;
   logic [XW-1:0] nxt_col;
   logic [YW-1:0] nxt_row;

   logic          idle;
   logic [CW-1:0] eff_cols;
   logic [RW-1:0] eff_rows;
   logic [QW-1:0] frame_len;
   logic [QW-1:0] last_step;
   logic          at_last;
   logic          ptr_end;
   logic          col_end;
   logic          cen_go;

   assign idle      = (step == '0);
   assign eff_cols  = idle ? cfg_cols : lat_cols;
   assign eff_rows  = idle ? cfg_rows : lat_rows;
   assign frame_len = QW'(eff_rows) * QW'(eff_cols);
   assign last_step = frame_len + QW'(eff_cols);
   assign at_last   = (step == last_step);
   assign ptr_end   = (CW'(ptr_q) == eff_cols - CW'(1));
   assign col_end   = (CW'(nxt_col) == eff_cols - CW'(1));

   // Real samples fill slots below frame_len; the rest of the frame is a
   // drain that runs one slot per cycle with zero data.
   assign in_ready    = (step < frame_len);
   assign adv         = in_ready ? in_valid : 1'b1;
   assign frame_start = adv && idle;
   // The cross of slot k is complete once slot k+cols+1 has been consumed.
   assign cen_go      = adv && (step > QW'(eff_cols));
   assign ptr         = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step      <= '0;
         ptr_q     <= '0;
         nxt_col   <= '0;
         nxt_row   <= '0;
         cen_valid <= 1'b0;
         cen_last  <= 1'b0;
         cen_row   <= '0;
         cen_col   <= '0;
         lat_cols  <= '0;
         lat_rows  <= '0;
      end else begin
         cen_valid <= cen_go;
         cen_last  <= cen_go && at_last;
         if (frame_start) begin
            lat_cols <= cfg_cols;
            lat_rows <= cfg_rows;
         end
         if (adv) begin
            step  <= at_last ? '0 : step + QW'(1);
            ptr_q <= (at_last || ptr_end) ? '0 : ptr_q + XW'(1);
         end
         if (cen_go) begin
            cen_row <= nxt_row;
            cen_col <= nxt_col;
            if (at_last) begin
               nxt_col <= '0;
               nxt_row <= '0;
            end else if (col_end) begin
               nxt_col <= '0;
               nxt_row <= nxt_row + YW'(1);
            end else begin
               nxt_col <= nxt_col + XW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/xzs_cluster_filter.sv
module xzs_cluster_filter
   import xzs_pkg::*;
#(
   parameter int unsigned DATA_W   = 12,
   parameter int unsigned MAX_COLS = 64,
   parameter int unsigned MAX_ROWS = 64,
   parameter int unsigned HI_MIN   = 1,
   parameter int unsigned LO_MIN   = 2,
   localparam int unsigned CW = $clog2(MAX_COLS + 1),
   localparam int unsigned RW = $clog2(MAX_ROWS + 1),
   localparam int unsigned XW = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1,
   localparam int unsigned YW = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     cfg_cols,
   input  logic [RW-1:0]     cfg_rows,
   input  logic [DATA_W-1:0] cfg_hi_thr,
   input  logic [DATA_W-1:0] cfg_lo_thr,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [YW-1:0]     out_row,
   output logic [XW-1:0]     out_col,
   output logic [DATA_W-1:0] out_data,
   output logic              out_eof
);

   localparam int unsigned QW = $clog2(MAX_ROWS * MAX_COLS + MAX_COLS + 1);

   if (DATA_W < 1) begin : g_bad_dw
      $error("xzs_cluster_filter: DATA_W must be at least 1");
   end
   if (MAX_COLS < 1 || MAX_ROWS < 1) begin : g_bad_dims
      $error("xzs_cluster_filter: frame dimensions must be at least 1");
   end

   // ---------------- sequencing ----------------
   logic          adv;
   logic          frame_start;
   logic [XW-1:0] ptr;
   logic          cen_valid;
   logic          cen_last;
   logic [YW-1:0] cen_row;
   logic [XW-1:0] cen_col;
   logic [CW-1:0] lat_cols;
   logic [RW-1:0] lat_rows;

   xzs_scan_ctrl #(
      .CW (CW), .RW (RW), .XW (XW), .YW (YW), .QW (QW)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_cols    (cfg_cols),
      .cfg_rows    (cfg_rows),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .adv         (adv),
      .frame_start (frame_start),
      .ptr         (ptr),
      .cen_valid   (cen_valid),
      .cen_last    (cen_last),
      .cen_row     (cen_row),
      .cen_col     (cen_col),
      .lat_cols    (lat_cols),
      .lat_rows    (lat_rows)
   );

   logic [DATA_W-1:0] hi_lat;
   logic [DATA_W-1:0] lo_lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_lat <= '0;
         lo_lat <= '0;
      end else if (frame_start) begin
         hi_lat <= cfg_hi_thr;
         lo_lat <= cfg_lo_thr;
      end
   end

   // ---------------- row delay chain ----------------
   logic [DATA_W-1:0] slot_data;
   logic [DATA_W-1:0] lb_wr [NLINES];
   logic [DATA_W-1:0] lb_rd [NLINES];

   assign slot_data = in_ready ? in_data : '0;

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      if (g == 0) begin : g_head
         assign lb_wr[g] = slot_data;
      end else begin : g_chain
         assign lb_wr[g] = lb_rd[g-1];
      end
      xzs_linebuf #(
         .DW (DATA_W), .DEPTH (MAX_COLS), .AW (XW)
      ) u_lb (
         .clk     (clk),
         .adv     (adv),
         .ptr     (ptr),
         .wr_data (lb_wr[g]),
         .rd_data (lb_rd[g])
      );
   end

   // After slot q is consumed: bot_q=x[q], mid_q=x[q-C], top_q=x[q-2C].
   // One further stage on each row places the centre at x[q-C-1].
   logic [DATA_W-1:0] bot_q, bot_q2;
   logic [DATA_W-1:0] mid_q, mid_q2, mid_q3;
   logic [DATA_W-1:0] top_q, top_q2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bot_q  <= '0;
         bot_q2 <= '0;
         mid_q  <= '0;
         mid_q2 <= '0;
         mid_q3 <= '0;
         top_q  <= '0;
         top_q2 <= '0;
      end else if (adv) begin
         bot_q  <= slot_data;
         bot_q2 <= bot_q;
         mid_q  <= lb_rd[0];
         mid_q2 <= mid_q;
         mid_q3 <= mid_q2;
         top_q  <= lb_rd[NLINES-1];
         top_q2 <= top_q;
      end
   end

   // ---------------- cross decision ----------------
   logic [NTAPS-1:0][DATA_W-1:0] taps;
   logic [NTAPS-1:0]             tap_en;
   logic                         keep;

   always_comb begin
      taps                = '0;
      taps[int'(TAP_C)]   = mid_q2;
      taps[int'(TAP_N)]   = top_q2;
      taps[int'(TAP_S)]   = bot_q2;
      taps[int'(TAP_W)]   = mid_q3;
      taps[int'(TAP_E)]   = mid_q;
      tap_en              = '0;
      tap_en[int'(TAP_C)] = 1'b1;
      tap_en[int'(TAP_N)] = (cen_row != '0);
      tap_en[int'(TAP_S)] = (RW'(cen_row) != lat_rows - RW'(1));
      tap_en[int'(TAP_W)] = (cen_col != '0);
      tap_en[int'(TAP_E)] = (CW'(cen_col) != lat_cols - CW'(1));
   end

   xzs_cross_eval #(
      .DW (DATA_W), .HI_MIN (HI_MIN), .LO_MIN (LO_MIN)
   ) u_eval (
      .taps   (taps),
      .tap_en (tap_en),
      .hi_thr (hi_lat),
      .lo_thr (lo_lat),
      .keep   (keep)
   );

   // ---------------- record register ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_eof   <= 1'b0;
         out_row   <= '0;
         out_col   <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= cen_valid && keep;
         out_eof   <= cen_valid && cen_last;
         if (cen_valid) begin
            out_row  <= cen_row;
            out_col  <= cen_col;
            out_data <= mid_q2;
         end
      end
   end

endmodule

// File: rtl/xzs_cluster_filter_chk.sv
module xzs_cluster_filter_chk #(
   parameter int unsigned CW = 7,
   parameter int unsigned RW = 7,
   parameter int unsigned XW = 6,
   parameter int unsigned YW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_eof,
   input logic [YW-1:0] out_row,
   input logic [XW-1:0] out_col,
   input logic [CW-1:0] lat_cols,
   input logic [RW-1:0] lat_rows
);

   logic [CW:0] low_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_run <= '0;
      end else begin
         low_run <= in_ready ? '0 : low_run + (CW+1)'(1);
      end
   end

   // R5: record coordinates lie inside the frame captured for it
   p_coord_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (CW'(out_col) < $past(lat_cols)) && (RW'(out_row) < $past(lat_rows)));

   // R6: the end-of-frame flag marks the bottom-right position
   p_eof_position_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> (CW'(out_col) == $past(lat_cols) - CW'(1)) &&
                  (RW'(out_row) == $past(lat_rows) - RW'(1)));

   // R6: the flag never lasts two cycles
   p_eof_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |=> !out_eof);

   // R6: back-to-back records inside a frame advance in raster order
   p_raster_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid) && !$past(out_eof)) |->
         ({out_row, out_col} > $past({out_row, out_col})));

   // R7: the drain keeps the input closed for exactly cols+1 cycles
   p_drain_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> (low_run == {1'b0, lat_cols} + (CW+1)'(1)));

endmodule

bind xzs_cluster_filter xzs_cluster_filter_chk #(
   .CW (CW), .RW (RW), .XW (XW), .YW (YW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_eof   (out_eof),
   .out_row   (out_row),
   .out_col   (out_col),
   .lat_cols  (lat_cols),
   .lat_rows  (lat_rows)
);

// File: tb/xzs_cluster_filter_bench.sv
module xzs_cluster_filter_bench;

   localparam int DW = 12;
   localparam int MC = 16;
   localparam int MR = 16;
   localparam int CW = $clog2(MC + 1);
   localparam int RW = $clog2(MR + 1);
   localparam int XW = $clog2(MC);
   localparam int YW = $clog2(MR);

   typedef struct packed {
      logic          kept;
      logic          eof;
      logic [YW-1:0] row;
      logic [XW-1:0] col;
      logic [DW-1:0] data;
   } rec_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_cols = CW'(4);
   logic [RW-1:0] cfg_rows = RW'(4);
   logic [DW-1:0] cfg_hi_thr = '0;
   logic [DW-1:0] cfg_lo_thr = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [YW-1:0] out_row;
   logic [XW-1:0] out_col;
   logic [DW-1:0] out_data;
   logic          out_eof;

   always #2 clk = ~clk;   // 250 MHz

   xzs_cluster_filter #(
      .DATA_W (DW), .MAX_COLS (MC), .MAX_ROWS (MR)
   ) u_xzs_cluster_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_cols   (cfg_cols),
      .cfg_rows   (cfg_rows),
      .cfg_hi_thr (cfg_hi_thr),
      .cfg_lo_thr (cfg_lo_thr),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .out_valid  (out_valid),
      .out_row    (out_row),
      .out_col    (out_col),
      .out_data   (out_data),
      .out_eof    (out_eof)
   );

   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   rec_t  expq[$];
   string tagq[$];
   logic [DW-1:0] img [MR][MC];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int pix(input int r, input int c, input int nr, input int nc);
      if (r < 0 || r >= nr || c < 0 || c >= nc) return 0;
      return int'(img[r][c]);
   endfunction

   task automatic clear_img();
      for (int r = 0; r < MR; r++)
         for (int c = 0; c < MC; c++)
            img[r][c] = '0;
   endtask

   // Scoreboard producer: reference decision per position from the requirements.
   task automatic build_expect(input int nr, input int nc, input int hi, input int lo,
                               input string tag);
      for (int r = 0; r < nr; r++) begin
         for (int c = 0; c < nc; c++) begin
            int v[5];
            int nh;
            int nl;
            rec_t e;
            v[0] = pix(r, c, nr, nc);
            v[1] = pix(r - 1, c, nr, nc);
            v[2] = pix(r + 1, c, nr, nc);
            v[3] = pix(r, c - 1, nr, nc);
            v[4] = pix(r, c + 1, nr, nc);
            nh = 0;
            nl = 0;
            for (int k = 0; k < 5; k++) begin
               if (v[k] > hi) nh++;
               if (v[k] > lo) nl++;
            end
            e.kept = (nh >= 1) && (nl >= 2);
            e.eof  = (r == nr - 1) && (c == nc - 1);
            e.row  = YW'(r);
            e.col  = XW'(c);
            e.data = DW'(v[0]);
            if (e.kept || e.eof) begin
               expq.push_back(e);
               tagq.push_back(tag);
            end
         end
      end
   endtask

   // Driver: pushes expectations, then streams the frame and checks the drain.
   task automatic drive_frame(input int nr, input int nc, input int hi, input int lo,
                              input bit gaps, input bit scramble, input string tag);
      int low_cycles;
      build_expect(nr, nc, hi, lo, tag);
      cfg_rows   = RW'(nr);
      cfg_cols   = CW'(nc);
      cfg_hi_thr = DW'(hi);
      cfg_lo_thr = DW'(lo);
      for (int r = 0; r < nr; r++) begin
         for (int c = 0; c < nc; c++) begin
            if (gaps && ((r + c) % 3 == 0)) begin
               in_valid = 1'b0;
               @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = img[r][c];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            if (scramble && r == 0 && c == 0) begin
               // R8: mid-frame configuration changes must be ignored
               cfg_rows   = RW'(2);
               cfg_cols   = CW'(3);
               cfg_hi_thr = '0;
               cfg_lo_thr = '0;
            end
         end
      end
      // R7: keep offering a full-scale value through the drain
      in_valid   = 1'b1;
      in_data    = '1;
      low_cycles = 0;
      while (!in_ready) begin
         low_cycles++;
         @(negedge clk);
      end
      in_valid = 1'b0;
      check(low_cycles == nc + 1, "R7", "drain cycles with in_ready low",
            low_cycles, nc + 1);
   endtask

   // Scoreboard consumer.
   always @(negedge clk) begin
      if (rst_n && (out_valid || out_eof)) begin
         if (expq.size() == 0) begin
            check(1'b0, "R2", "unexpected record", {out_row, out_col}, 0);
         end else begin
            rec_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(out_valid == e.kept, t, $sformatf("keep decision at (%0d,%0d)", e.row, e.col),
                  out_valid, e.kept);
            check(out_eof == e.eof, "R6", $sformatf("eof flag at (%0d,%0d)", e.row, e.col),
                  out_eof, e.eof);
            if (e.kept) begin
               check({out_row, out_col, out_data} == {e.row, e.col, e.data}, "R5",
                     "record fields {row,col,data}",
                     {out_row, out_col, out_data}, {e.row, e.col, e.data});
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "R6", "watchdog expired", expq.size(), 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during reset
      check(!out_valid && !out_eof, "R1", "outputs during reset",
            {out_valid, out_eof}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && !out_eof && in_ready, "R1", "state after reset",
            {out_valid, out_eof, in_ready}, 3'b001);

      // R2: a lone seed has only one value above the low threshold anywhere
      clear_img();
      img[2][3] = 12'd150;
      drive_frame(5, 6, 100, 20, 1'b0, 1'b0, "R2");

      // R2 with idle cycles inside the frame (R9)
      clear_img();
      img[2][2] = 12'd150;
      img[2][3] = 12'd40;
      img[3][2] = 12'd30;
      img[5][7] = 12'd15;
      drive_frame(6, 8, 100, 20, 1'b1, 1'b0, "R9");

      // R3: values equal to a threshold do not count
      clear_img();
      img[1][1] = 12'd100;
      img[1][2] = 12'd20;
      img[2][1] = 12'd101;
      drive_frame(4, 4, 100, 20, 1'b0, 1'b0, "R3");

      // R4: stream-adjacent but frame-distant values must not pair up
      clear_img();
      img[1][5] = 12'd80;
      img[2][0] = 12'd80;
      drive_frame(5, 6, 50, 10, 1'b0, 1'b0, "R4");

      // R4: saturated bottom row, then a frame whose top row must not see it
      clear_img();
      for (int c = 0; c < 6; c++) img[3][c] = 12'd200;
      drive_frame(4, 6, 100, 20, 1'b0, 1'b0, "R4");
      clear_img();
      img[0][2] = 12'd150;
      drive_frame(4, 6, 100, 20, 1'b0, 1'b0, "R4");

      // R8: configuration scrambled right after the first sample
      clear_img();
      img[2][2] = 12'd130;
      img[2][1] = 12'd25;
      img[1][2] = 12'd3;
      drive_frame(5, 5, 100, 20, 1'b0, 1'b1, "R8");

      // R4: single column, neighbours only above and below
      clear_img();
      img[2][0] = 12'd120;
      img[3][0] = 12'd110;
      drive_frame(6, 1, 100, 20, 1'b1, 1'b0, "R4");

      // R4: single row, neighbours only left and right
      clear_img();
      img[0][3] = 12'd150;
      img[0][4] = 12'd50;
      drive_frame(1, 7, 100, 20, 1'b0, 1'b0, "R4");

      // R2: full-size frame with a computed texture
      for (int r = 0; r < MR; r++)
         for (int c = 0; c < MC; c++)
            img[r][c] = DW'(((r * 7 + c * 13) % 11) * 12);
      drive_frame(MR, MC, 100, 60, 1'b1, 1'b0, "R2");

      for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
      check(expq.size() == 0, "R6", "records still outstanding", expq.size(), 0);
      check(!out_valid && !out_eof, "R9", "quiet output with no input",
            {out_valid, out_eof}, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule